// File: doc/BRIEF.md
# Segmented Address Mapper with Mirroring

This block translates a processor address into an offset within one flat physical memory array. The address space is split into four regions. Below 1 MB, a small ROM repeats. Above that sits a contiguous extension region. At the top is a high region that holds on-chip RAM and peripherals. Between the extension region and the high region is an unmapped hole. In the two highest 4 KB pages, a 1 KB window is repeated four times before the high region is relocated.

The translation itself is combinational. Any strobed access that lands in the hole raises `fault_o` in the same cycle, forces the offset to zero and blocks the write enable, so valid memory cannot be corrupted. Each fault is also latched into a sticky flag, which stays set until the clear input is pulsed. The ROM size and both region boundaries are parameters. The base of the high region in the array is derived from them.

Top module: `seg_addr_map`

## Requirements
- R1: Only bits 23:0 of `addr_i` take part in translation, so changing bits 31:24 never changes any output.
- R2: For addresses below 0x100000, `phys_o` is the address modulo ROM_SIZE (default 0x40000), which must be a power of two.
- R3: For addresses from 0x100000 up to, but not including, LOW_END (default 0x180000), `phys_o` is addr − 0x100000 + ROM_SIZE.
- R4: For addresses at or above HIGH_START (default 0xFF0000), `phys_o` is addr − HIGH_START + HIGH_BASE, where HIGH_BASE = ROM_SIZE + LOW_END − 0x100000 (default 0xC0000).
- R5: In the page 0xFFF000–0xFFFFFF, address bits 11:10 are cleared before R4 is applied, so a 1 KB window repeats four times.
- R6: In the page 0xFFE000–0xFFEFFF, address bits 11:10 are cleared in the same way before R4 is applied.
- R7: A strobed access with LOW_END ≤ addr < HIGH_START drives `fault_o` high in the same cycle, drives `phys_o` to zero and holds `we_o` low.
- R8: `we_o` follows `we_i` for a strobed access outside the hole. With `req_i` low, both `we_o` and `fault_o` are low.
- R9: `fault_sticky_o` is set at the clock edge that ends a faulting cycle and holds its value while there is no clear and no fault.
- R10: `clr_fault_i` clears `fault_sticky_o` at the next edge, unless a fault occurs in that same cycle, in which case the flag stays set.
- R11: While `rst_ni` is low, `fault_sticky_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Processor address |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write request |
| clr_fault_i | input | 1 | Clears the sticky fault flag |
| phys_o | output | 24 | Offset into the physical array |
| we_o | output | 1 | Gated write enable |
| fault_o | output | 1 | Same-cycle fault for a hole access |
| fault_sticky_o | output | 1 | Latched fault flag |

## Verification
Two functions can act in the same cycle: a fault that sets the sticky flag, and a clear pulse that resets it. The bench provokes this by presenting a strobed hole address while `clr_fault_i` is high in the same cycle. After that edge it expects the flag to remain set. A clear alone in the following cycle must then drop the flag. This pins the priority of set over clear, a priority that a lone clear or a lone fault could not reveal.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
  typedef enum logic [1:0] {
    RG_ROM  = 2'd0,
    RG_EXT  = 2'd1,
    RG_HOLE = 2'd2,
    RG_HIGH = 2'd3
  } region_e;

  localparam int unsigned EXT_BASE = 32'h0010_0000;
endpackage

// File: rtl/seg_region_decode.sv
module seg_region_decode
  import seg_map_pkg::*;
#(
  parameter int unsigned LOCAL_W    = 24,
  parameter int unsigned LOW_END    = 32'h0018_0000,
  parameter int unsigned HIGH_START = 32'h00FF_0000
) (
  input  logic [LOCAL_W-1:0] addr_i,
  output region_e            region_o
);
  localparam logic [LOCAL_W-1:0] EXT_L  = LOCAL_W'(EXT_BASE);
  localparam logic [LOCAL_W-1:0] LOW_L  = LOCAL_W'(LOW_END);
  localparam logic [LOCAL_W-1:0] HIGH_L = LOCAL_W'(HIGH_START);

  always_comb begin
    if (addr_i < EXT_L)        region_o = RG_ROM;
    else if (addr_i < LOW_L)   region_o = RG_EXT;
    else if (addr_i >= HIGH_L) region_o = RG_HIGH;
    else                       region_o = RG_HOLE;
  end
endmodule

// File: rtl/seg_offset_fold.sv
module seg_offset_fold
  import seg_map_pkg::*;
#(
  parameter int unsigned LOCAL_W     = 24,
  parameter int unsigned ROM_SIZE    = 32'h0004_0000,
  parameter int unsigned LOW_END     = 32'h0018_0000,
  parameter int unsigned HIGH_START  = 32'h00FF_0000,
  parameter int unsigned ALIAS_PAGES = 2
) (
  input  logic [LOCAL_W-1:0] addr_i,
  input  region_e            region_i,
  output logic [LOCAL_W-1:0] phys_o
);
  localparam int unsigned PG_W = LOCAL_W - 12;
  localparam logic [LOCAL_W-1:0] ROM_L   = LOCAL_W'(ROM_SIZE);
  localparam logic [LOCAL_W-1:0] EXT_L   = LOCAL_W'(EXT_BASE);
  localparam logic [LOCAL_W-1:0] HIGH_L  = LOCAL_W'(HIGH_START);
  localparam logic [LOCAL_W-1:0] HBASE_L = LOCAL_W'(ROM_SIZE + LOW_END - EXT_BASE);
  localparam logic [LOCAL_W-1:0] FOLD_M  = ~(LOCAL_W'(3) << 10);

  logic [ALIAS_PAGES-1:0] page_hit;
  logic [LOCAL_W-1:0]     aliased;

  // top pages each alias a 1 KB window across 4 KB
  for (genvar p = 0; p < ALIAS_PAGES; p++) begin : g_page
    localparam logic [PG_W-1:0] PG = PG_W'((2 ** PG_W) - 1 - p);
    assign page_hit[p] = (addr_i[LOCAL_W-1:12] == PG);
  end

  assign aliased = (|page_hit) ? (addr_i & FOLD_M) : addr_i;

  always_comb begin
    unique case (region_i)
      RG_ROM:  phys_o = addr_i & (ROM_L - LOCAL_W'(1));
      RG_EXT:  phys_o = addr_i - EXT_L + ROM_L;
      RG_HIGH: phys_o = aliased - HIGH_L + HBASE_L;
      default: phys_o = '0;
    endcase
  end
endmodule

// File: rtl/seg_fault_reg.sv
module seg_fault_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_o <= 1'b0;
    else if (set_i)  sticky_o <= 1'b1;  // set beats clear
    else if (clr_i)  sticky_o <= 1'b0;
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(sticky_o));
endmodule

// File: rtl/seg_addr_map.sv
module seg_addr_map
  import seg_map_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LOCAL_W     = 24,
  parameter int unsigned ROM_SIZE    = 32'h0004_0000,
  parameter int unsigned LOW_END     = 32'h0018_0000,
  parameter int unsigned HIGH_START  = 32'h00FF_0000,
  parameter int unsigned ALIAS_PAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               clr_fault_i,
  output logic [LOCAL_W-1:0] phys_o,
  output logic               we_o,
  output logic               fault_o,
  output logic               fault_sticky_o
);
  logic [LOCAL_W-1:0] local_addr;
  logic               unused_hi;
  region_e            region;
  logic               in_hole;

  assign local_addr = addr_i[LOCAL_W-1:0];
  assign unused_hi  = ^addr_i[ADDR_W-1:LOCAL_W];

  seg_region_decode #(
    .LOCAL_W    (LOCAL_W),
    .LOW_END    (LOW_END),
    .HIGH_START (HIGH_START)
  ) i_decode (
    .addr_i   (local_addr),
    .region_o (region)
  );

  seg_offset_fold #(
    .LOCAL_W     (LOCAL_W),
    .ROM_SIZE    (ROM_SIZE),
    .LOW_END     (LOW_END),
    .HIGH_START  (HIGH_START),
    .ALIAS_PAGES (ALIAS_PAGES)
  ) i_fold (
    .addr_i   (local_addr),
    .region_i (region),
    .phys_o   (phys_o)
  );

  assign in_hole = (region == RG_HOLE);
  assign fault_o = req_i && in_hole;
  assign we_o    = req_i && we_i && !in_hole;

  seg_fault_reg i_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (fault_o),
    .clr_i    (clr_fault_i),
    .sticky_o (fault_sticky_o)
  );

  // R7
  fault_zero_phys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (phys_o == '0) && !we_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !we_o && !fault_o);

  // R9
  fault_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_sticky_o);

  // R10
  clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_fault_i && !fault_o) |=> !fault_sticky_o);
endmodule

// File: tb/test_seg_addr_map.sv
module test_seg_addr_map;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic        clr_fault_i = 1'b0;
  logic [23:0] phys_o;
  logic        we_o, fault_o, fault_sticky_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  seg_addr_map i_seg_addr_map (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr_i),
    .req_i          (req_i),
    .we_i           (we_i),
    .clr_fault_i    (clr_fault_i),
    .phys_o         (phys_o),
    .we_o           (we_o),
    .fault_o        (fault_o),
    .fault_sticky_o (fault_sticky_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic rq, input logic w, input logic clr);
    @(negedge clk_i);
    addr_i = a; req_i = rq; we_i = w; clr_fault_i = clr;
    #1;
  endtask

  task automatic map_chk(input string tag, input logic [31:0] a, input logic [23:0] exp);
    drive(a, 1'b1, 1'b0, 1'b0);
    chk(tag, 32'(phys_o), 32'(exp));
    chk(tag, 32'(fault_o), 32'd0);
  endtask

  task automatic test_reset();
    chk("R11 sticky in reset", 32'(fault_sticky_o), 32'd0);
  endtask

  task automatic test_rom_mirror();
    map_chk("R2 rom base", 32'h0001_2345, 24'h01_2345);
    map_chk("R2 rom mirror", 32'h000C_1234, 24'h00_1234);
    map_chk("R2 rom top", 32'h000F_FFFF, 24'h03_FFFF);
  endtask

  task automatic test_upper_ignored();
    map_chk("R1 upper bits", 32'hAB0C_1234, 24'h00_1234);
    map_chk("R1 upper bits high", 32'h5AFF_1234, 24'h0C_1234);
  endtask

  task automatic test_ext();
    map_chk("R3 ext start", 32'h0010_0000, 24'h04_0000);
    map_chk("R3 ext end", 32'h0017_FFFF, 24'h0B_FFFF);
  endtask

  task automatic test_high();
    map_chk("R4 high start", 32'h00FF_0000, 24'h0C_0000);
    map_chk("R4 high no alias", 32'h00FF_1C34, 24'h0C_1C34);
    map_chk("R4 below ram page", 32'h00FF_DC00, 24'h0C_DC00);
  endtask

  task automatic test_alias();
    map_chk("R5 periph base", 32'h00FF_F123, 24'h0C_F123);
    map_chk("R5 periph alias", 32'h00FF_F7FF, 24'h0C_F3FF);
    map_chk("R5 periph top", 32'h00FF_FFFF, 24'h0C_F3FF);
    map_chk("R6 ram alias", 32'h00FF_EC10, 24'h0C_E010);
    map_chk("R6 ram alias2", 32'h00FF_E4AA, 24'h0C_E0AA);
  endtask

  task automatic test_we();
    drive(32'h0010_0010, 1'b1, 1'b1, 1'b0);
    chk("R8 we passes", 32'(we_o), 32'd1);
    drive(32'h0010_0010, 1'b0, 1'b1, 1'b0);
    chk("R8 no req we", 32'(we_o), 32'd0);
    drive(32'h0020_0000, 1'b0, 1'b1, 1'b0);
    chk("R8 no req fault", 32'(fault_o), 32'd0);
    @(negedge clk_i);
    chk("R8 no req sticky", 32'(fault_sticky_o), 32'd0);
  endtask

  task automatic test_hole();
    drive(32'h0018_0000, 1'b1, 1'b1, 1'b0);
    chk("R7 hole fault", 32'(fault_o), 32'd1);
    chk("R7 hole phys", 32'(phys_o), 32'd0);
    chk("R7 hole we", 32'(we_o), 32'd0);
    drive(32'h00FE_FFFF, 1'b1, 1'b1, 1'b0);
    chk("R7 hole top fault", 32'(fault_o), 32'd1);
    chk("R7 hole top we", 32'(we_o), 32'd0);
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R9 sticky set", 32'(fault_sticky_o), 32'd1);
    @(negedge clk_i);
    chk("R9 sticky held", 32'(fault_sticky_o), 32'd1);
  endtask

  task automatic test_clear_collision();
    drive(32'h0040_0000, 1'b1, 1'b0, 1'b1);
    chk("R10 collide fault", 32'(fault_o), 32'd1);
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b1);
    chk("R10 set beats clear", 32'(fault_sticky_o), 32'd1);
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R10 clear alone", 32'(fault_sticky_o), 32'd0);
  endtask

  initial begin
    #5;
    test_reset();
    #30;
    @(negedge clk_i);
    rst_ni = 1'b1;
    test_rom_mirror();
    test_upper_ignored();
    test_ext();
    test_high();
    test_alias();
    test_we();
    test_hole();
    test_clear_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule